// File: doc/BRIEF.md
# Single-wire bus slot monitor

This block listens passively to a sampled open-drain single-wire bus, the kind where one master and its devices share one pulled-up line and every transaction is timed from the master's falling edges. It measures how long the line stays low and how long it stays high in clock ticks. From those durations it sorts each time slot into one of two kinds. A data slot yields one bit. A reset slot is a long low pulse, followed by a window in which devices may answer by pulling the line low.

The monitor also follows the bus speed. After a full-length reset it gathers the first eight bits as a command byte. Two command values move the bus to the fast timing set, and a full-length reset moves it back. Every threshold the monitor compares against (the bit sample point, the slot length, the presence sample point and the reset-slot length) is taken from the timing set that is active at that moment. All thresholds are parameters. The raw line goes through a two-flop synchronizer, and an edge is found by comparing the synchronized sample with the one before it.

Top module: `line_slot_monitor`

## Requirements
- R1: After reset, `bit_valid` and `rst_valid` are low and `od_active` is 0 (standard timing).
- R2: The bit value is the synchronized line level SAMPLE ticks after the detected falling edge, where SAMPLE is 15 at standard timing and 2 at fast timing. Successive bits then arrive LSB-first.
- R3: If the line is high SLOT ticks after the falling edge (60 standard, 8 fast), exactly one `bit_valid` pulse is given. If the line is still low at that tick, no bit is given. A rise that then meets no reset threshold returns the monitor to idle with no strobe.
- R4: A low duration longer than 400 ticks (the standard reset threshold) is a reset at any speed. It clears `od_active` and restarts command collection. A low of 398 ticks is not a reset and a low of 402 ticks is.
- R5: While `od_active` is 1, a low duration longer than 48 ticks (the fast reset threshold) and no longer than 400 is also a reset, and `od_active` stays 1. At fast timing a low of 30 ticks gives no strobe.
- R6: After a reset, the line is sampled PRESENCE ticks after the rising edge (70 standard, 8 fast). `presence` reports 1 when the line was low at that tick.
- R7: RESET_END ticks after the rising edge (480 standard, 48 fast), a high line gives one `rst_valid` pulse carrying `presence`. A low line at that tick gives no strobe, and the rise that follows is measured again as a possible reset.
- R8: The first 8 bits after a standard reset form the command byte, LSB-first. The value 0x3C or 0x69 sets `od_active` in the same cycle as the 8th `bit_valid` pulse. Any other value leaves it at 0.
- R9: Bits after the 8th never change the command byte and never set `od_active`.
- R10: The duration counter saturates at 2^CNT_W-1. A low of 4196 ticks (more than 4096) is still a reset.
- R11: `bit_valid` and `rst_valid` are single-cycle pulses and are never high together.
- R12: The line passes two synchronizer flops. With the line driven low just after a clock edge, and high again well before the slot-length tick, `bit_valid` rises on the 63rd following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 1 | Raw bus level (1 = released/high) |
| bit_valid | output | 1 | One-cycle pulse: a data bit was decoded |
| bit_value | output | 1 | Decoded bit, valid with `bit_valid` |
| rst_valid | output | 1 | One-cycle pulse: a reset slot completed |
| presence | output | 1 | 1 when a device answered, valid with `rst_valid` |
| od_active | output | 1 | 1 while the fast timing set is in use |

## Verification
The assertions assume that the line does not glitch around the sample ticks and that the thresholds are ordered: sample before slot end, slot end before either reset threshold, and presence sample before reset end. They also assume the bus idles high out of reset, because the synchronizer starts in the released state. The stimulus keeps every low and high phase at least two ticks away from the threshold it tests, gives each slot enough recovery that the monitor is idle before the next falling edge, and keeps device answers well inside the presence window.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    // Slot decoder phases
    typedef enum logic [2:0] {
        ST_IDLE,        // waiting for a falling edge
        ST_BIT_SAMPLE,  // counting to the bit sample tick
        ST_BIT_END,     // counting to the slot end tick
        ST_WAIT_HIGH,   // line held low past slot end; measure the low
        ST_PRES_SAMPLE, // counting to the presence sample tick
        ST_RST_END      // counting to the end of the reset slot
    } lsm_state_e;
endpackage

// File: rtl/lsm_line_sync.sv
// Two-flop synchronizer for the raw bus line, plus a one-sample history
// register, so that edges come from comparing consecutive samples.
// Assumes the bus idles high, so every stage resets to 1.
module lsm_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_fall,
    output logic line_rise
);
    logic meta_q;
    logic samp_q;
    logic prev_q;

    // Sync chain and history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            samp_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_raw;
            samp_q <= meta_q;
            prev_q <= samp_q;
        end
    end

    assign line_s    = samp_q;
    assign line_fall = prev_q & ~samp_q;
    assign line_rise = ~prev_q & samp_q;

    // R12: the synchronized level follows the raw line two edges later
    assert_sync_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (samp_q == $past(line_raw, 2)));
endmodule

// File: rtl/lsm_dur_counter.sv
// Tick counter for the duration since the last marked edge. A restart
// loads 1, so the value equals the ticks elapsed since the marking cycle.
// It saturates at its maximum so that a very long low can never wrap.
module lsm_dur_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Restart, count up, or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_MAX;
        else if (restart)
            cnt_q <= CNT_ONE;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_ONE;
    end

    assign count = cnt_q;

    // R10: once at the ceiling, the count stays there until a restart
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX));
    // R10: a restart always yields one elapsed tick
    assert_restart_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == CNT_ONE));
endmodule

// File: rtl/lsm_cmd_track.sv
// Collects the first CMD_BITS decoded bits after a standard reset,
// LSB-first, and raises the fast-timing flag when the finished byte
// matches either selector value. Later bits are ignored. Assumes
// bit_take and std_clear never arrive in the same cycle.
module lsm_cmd_track #(
    parameter int          CMD_BITS = 8,
    parameter int unsigned SEL_A    = 'h3C,
    parameter int unsigned SEL_B    = 'h69
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_take,
    input  logic bit_val,
    input  logic std_clear,
    output logic fast_mode
);
    localparam int CW = $clog2(CMD_BITS + 1);
    localparam int IW = (CMD_BITS > 1) ? $clog2(CMD_BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CMD_BITS - 1);
    localparam logic [CW-1:0] FULL = CW'(CMD_BITS);
    localparam logic [CW-1:0] CW_ONE = CW'(1);
    localparam logic [CMD_BITS-1:0] PAT_A = CMD_BITS'(SEL_A);
    localparam logic [CMD_BITS-1:0] PAT_B = CMD_BITS'(SEL_B);

    logic [CW-1:0]       got_q;
    logic [CMD_BITS-1:0] cmd_q;
    logic [CMD_BITS-1:0] cmd_next;
    logic                fast_q;

    // Command byte with the incoming bit inserted at its position.
    always_comb begin
        cmd_next = cmd_q;
        cmd_next[got_q[IW-1:0]] = bit_val;
    end

    // Bit collection and the one-time selector check.
    always_ff @(posedge clk) begin
        if (!rst_n || std_clear) begin
            got_q  <= '0;
            cmd_q  <= '0;
            fast_q <= 1'b0;
        end else if (bit_take && got_q != FULL) begin
            cmd_q <= cmd_next;
            got_q <= got_q + CW_ONE;
            if (got_q == LAST && (cmd_next == PAT_A || cmd_next == PAT_B))
                fast_q <= 1'b1;
        end
    end

    assign fast_mode = fast_q;

    // R4: a standard reset clears the speed and the collection
    assert_std_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        std_clear |=> (!fast_q && got_q == '0));
    // R8: the flag can only rise with the last command bit
    assert_fast_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_take && got_q == LAST) |=> !$rose(fast_q));
    // R9: once full, the command byte is frozen until a standard reset
    assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (got_q == FULL && !std_clear) |=> $stable(cmd_q));
endmodule

// File: rtl/line_slot_monitor.sv
// Passive slot monitor for a single-wire open-drain bus. It times the
// low and high phases after each falling edge, decodes data bits and
// reset/presence sequences, and tracks standard versus fast timing.
// Assumes: the thresholds are ordered (sample < slot < fast reset
// < standard reset, and presence sample < reset end), all are at least 1,
// and all fit in CNT_W bits.
module line_slot_monitor #(
    parameter int          CNT_W       = 12,
    parameter int          STD_SAMPLE  = 15,
    parameter int          STD_SLOT    = 60,
    parameter int          STD_RST     = 400,
    parameter int          STD_PRES    = 70,
    parameter int          STD_RST_END = 480,
    parameter int          OD_SAMPLE   = 2,
    parameter int          OD_SLOT     = 8,
    parameter int          OD_RST      = 48,
    parameter int          OD_PRES     = 8,
    parameter int          OD_RST_END  = 48,
    parameter int          CMD_BITS    = 8,
    parameter int unsigned OD_SEL_A    = 'h3C,
    parameter int unsigned OD_SEL_B    = 'h69
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic bit_valid,
    output logic bit_value,
    output logic rst_valid,
    output logic presence,
    output logic od_active
);
    import lsm_pkg::*;

    // Thresholds per timing set: index 0 standard, index 1 fast.
    localparam int NSETS = 2;
    localparam logic [CNT_W-1:0] T_STD_RST = CNT_W'(STD_RST);
    localparam logic [CNT_W-1:0] T_OD_RST  = CNT_W'(OD_RST);

    logic [CNT_W-1:0] tab_sample [NSETS];
    logic [CNT_W-1:0] tab_slot   [NSETS];
    logic [CNT_W-1:0] tab_pres   [NSETS];
    logic [CNT_W-1:0] tab_rend   [NSETS];

    genvar gi;
    generate
        for (gi = 0; gi < NSETS; gi++) begin : g_sets
            assign tab_sample[gi] = CNT_W'((gi == 0) ? STD_SAMPLE  : OD_SAMPLE);
            assign tab_slot[gi]   = CNT_W'((gi == 0) ? STD_SLOT    : OD_SLOT);
            assign tab_pres[gi]   = CNT_W'((gi == 0) ? STD_PRES    : OD_PRES);
            assign tab_rend[gi]   = CNT_W'((gi == 0) ? STD_RST_END : OD_RST_END);
        end
    endgenerate

    logic             line_s, line_fall, line_rise;
    logic [CNT_W-1:0] dur;
    logic             restart;
    logic             fast;
    lsm_state_e       st_q, st_n;

    logic cap_bit, cap_pres, take_bit, std_rst, fast_rst, done_rst;
    logic bit_cap_q, pres_lvl_q;
    logic bit_valid_q, bit_value_q, rst_valid_q, presence_q;
    logic [CNT_W-1:0] t_sample, t_slot, t_pres, t_rend;

    lsm_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (bus_in),
        .line_s   (line_s),
        .line_fall(line_fall),
        .line_rise(line_rise)
    );

    lsm_dur_counter #(.CNT_W(CNT_W)) u_dur (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .count  (dur)
    );

    lsm_cmd_track #(
        .CMD_BITS(CMD_BITS),
        .SEL_A   (OD_SEL_A),
        .SEL_B   (OD_SEL_B)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_take (take_bit),
        .bit_val  (bit_cap_q),
        .std_clear(std_rst),
        .fast_mode(fast)
    );

    // Pick the thresholds of the timing set in use.
    always_comb begin
        t_sample = tab_sample[fast];
        t_slot   = tab_slot[fast];
        t_pres   = tab_pres[fast];
        t_rend   = tab_rend[fast];
    end

    // Slot decoder: next phase and the events of this tick.
    always_comb begin
        st_n     = st_q;
        restart  = 1'b0;
        cap_bit  = 1'b0;
        cap_pres = 1'b0;
        take_bit = 1'b0;
        std_rst  = 1'b0;
        fast_rst = 1'b0;
        done_rst = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (line_fall) begin
                    restart = 1'b1;
                    st_n    = ST_BIT_SAMPLE;
                end
            end
            ST_BIT_SAMPLE: begin
                if (dur == t_sample) begin
                    cap_bit = 1'b1;
                    st_n    = ST_BIT_END;
                end
            end
            ST_BIT_END: begin
                if (dur == t_slot) begin
                    if (line_s) begin
                        take_bit = 1'b1;
                        st_n     = ST_IDLE;
                    end else begin
                        st_n = ST_WAIT_HIGH;
                    end
                end
            end
            ST_WAIT_HIGH: begin
                if (line_s) begin
                    if (dur > T_STD_RST) begin
                        std_rst = 1'b1;
                        restart = 1'b1;
                        st_n    = ST_PRES_SAMPLE;
                    end else if (fast && dur > T_OD_RST) begin
                        fast_rst = 1'b1;
                        restart  = 1'b1;
                        st_n     = ST_PRES_SAMPLE;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_PRES_SAMPLE: begin
                if (dur == t_pres) begin
                    cap_pres = 1'b1;
                    st_n     = ST_RST_END;
                end
            end
            ST_RST_END: begin
                if (dur == t_rend) begin
                    if (line_s) begin
                        done_rst = 1'b1;
                        st_n     = ST_IDLE;
                    end else begin
                        st_n = ST_WAIT_HIGH;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Phase register and captured line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            bit_cap_q  <= 1'b0;
            pres_lvl_q <= 1'b1;
        end else begin
            st_q <= st_n;
            if (cap_bit)
                bit_cap_q <= line_s;
            if (cap_pres)
                pres_lvl_q <= line_s;
        end
    end

    // Registered output strobes and their data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid_q <= 1'b0;
            bit_value_q <= 1'b0;
            rst_valid_q <= 1'b0;
            presence_q  <= 1'b0;
        end else begin
            bit_valid_q <= take_bit;
            rst_valid_q <= done_rst;
            if (take_bit)
                bit_value_q <= bit_cap_q;
            if (done_rst)
                presence_q <= ~pres_lvl_q;
        end
    end

    assign bit_valid = bit_valid_q;
    assign bit_value = bit_value_q;
    assign rst_valid = rst_valid_q;
    assign presence  = presence_q;
    assign od_active = fast;

    // R3: a bit is only reported when the line was high at the slot end
    assert_bit_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(line_s));
    // R11: the strobes never overlap
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && rst_valid));
    // R11: each strobe lasts a single cycle
    assert_bit_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    assert_rst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_valid |=> !rst_valid);
    // R5: a fast-length reset keeps the fast timing
    assert_fast_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fast_rst |=> od_active);
    // R7: a reset is reported only from the end of a reset slot
    assert_rst_from_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_valid |-> $past(st_q == ST_RST_END && line_s));
    // R1: one edge after reset release, nothing is reported
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!bit_valid && !rst_valid && !od_active));
endmodule

// File: tb/line_slot_monitor_test.sv
module line_slot_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus = 1'b1;
    logic bit_valid, bit_value, rst_valid, presence, od_active;

    int total = 0;
    int bad = 0;
    int nbit = 0;
    int nrst = 0;
    logic last_pres = 1'b0;
    logic od_at_bit = 1'b0;
    logic [7:0] rxbyte = 8'h00;

    always #5 clk = ~clk;

    line_slot_monitor uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus),
        .bit_valid(bit_valid),
        .bit_value(bit_value),
        .rst_valid(rst_valid),
        .presence (presence),
        .od_active(od_active)
    );

    // Observe strobes away from the active edge.
    always @(negedge clk) begin
        if (bit_valid) begin
            nbit++;
            rxbyte = {bit_value, rxbyte[7:1]};
            od_at_bit = od_active;
        end
        if (rst_valid) begin
            nrst++;
            last_pres = presence;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        bus = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic std_bit(input logic b);
        hold(1'b0, b ? 5 : 30);
        hold(1'b1, b ? 65 : 40);
    endtask

    task automatic od_bit(input logic b);
        hold(1'b0, b ? 1 : 5);
        hold(1'b1, b ? 13 : 9);
    endtask

    task automatic std_reset(input int low, input logic dev);
        hold(1'b0, low);
        if (dev) begin
            hold(1'b1, 20);
            hold(1'b0, 100);
            hold(1'b1, 400);
        end else begin
            hold(1'b1, 520);
        end
    endtask

    task automatic od_reset(input int low, input logic dev);
        hold(1'b0, low);
        if (dev) begin
            hold(1'b1, 3);
            hold(1'b0, 12);
            hold(1'b1, 45);
        end else begin
            hold(1'b1, 60);
        end
    endtask

    task automatic std_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) std_bit(v[i]);
    endtask

    task automatic od_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) od_bit(v[i]);
    endtask

    task automatic t_reset_state;
        chk("R1 bit_valid after reset", bit_valid, 0);
        chk("R1 rst_valid after reset", rst_valid, 0);
        chk("R1 od_active after reset", od_active, 0);
    endtask

    task automatic t_std_traffic;
        int r0, b0;
        r0 = nrst;
        std_reset(500, 1'b1);
        chk("R4 reset strobe count", nrst - r0, 1);
        chk("R6 presence answered", last_pres, 1);
        b0 = nbit;
        std_byte(8'hA5);
        chk("R3 eight bit strobes", nbit - b0, 8);
        chk("R2 byte LSB-first", rxbyte, 8'hA5);
        chk("R8 other command keeps standard", od_active, 0);
        r0 = nrst;
        std_reset(500, 1'b0);
        chk("R7 reset strobe without device", nrst - r0, 1);
        chk("R6 presence absent", last_pres, 0);
    endtask

    task automatic t_sync_latency;
        int b0;
        b0 = nbit;
        hold(1'b0, 5);
        hold(1'b1, 56);
        @(negedge clk);
        chk("R12 no strobe at edge 62", bit_valid, 0);
        @(negedge clk);
        chk("R12 strobe at edge 63", bit_valid, 1);
        chk("R2 bit one value", bit_value, 1);
        @(negedge clk);
        chk("R11 strobe lasts one cycle", bit_valid, 0);
        hold(1'b1, 6);
        chk("R11 single strobe", nbit - b0, 1);
    endtask

    task automatic t_long_lows;
        int b0, r0;
        b0 = nbit; r0 = nrst;
        hold(1'b0, 100);
        hold(1'b1, 100);
        chk("R3 low past slot end gives no bit", nbit - b0, 0);
        chk("R3 low past slot end gives no reset", nrst - r0, 0);
        hold(1'b0, 398);
        hold(1'b1, 600);
        chk("R4 low 398 is not a reset", nrst - r0, 0);
        std_reset(402, 1'b0);
        chk("R4 low 402 is a reset", nrst - r0, 1);
    endtask

    task automatic t_fast_entry(input logic [7:0] sel);
        int r0, b0;
        std_reset(500, 1'b1);
        for (int i = 0; i < 7; i++) std_bit(sel[i]);
        chk("R8 not fast before 8th bit", od_active, 0);
        std_bit(sel[7]);
        chk("R8 fast with 8th bit strobe", od_at_bit, 1);
        chk("R8 fast selector byte", rxbyte, sel);
        b0 = nbit;
        od_byte(8'h96);
        chk("R2 fast bit count", nbit - b0, 8);
        chk("R2 fast byte LSB-first", rxbyte, 8'h96);
        r0 = nrst;
        od_reset(60, 1'b1);
        chk("R5 fast reset strobe", nrst - r0, 1);
        chk("R6 fast presence", last_pres, 1);
        chk("R5 fast kept after fast reset", od_active, 1);
        b0 = nbit;
        hold(1'b0, 30);
        hold(1'b1, 30);
        chk("R5 fast low 30 no bit", nbit - b0, 0);
        chk("R5 fast low 30 no reset", nrst - r0, 1);
        r0 = nrst;
        std_reset(500, 1'b0);
        chk("R4 standard reset strobe from fast", nrst - r0, 1);
        chk("R4 standard reset leaves fast", od_active, 0);
    endtask

    task automatic t_first_byte_only;
        std_reset(500, 1'b0);
        std_byte(8'h55);
        chk("R8 0x55 stays standard", od_active, 0);
        std_byte(8'h3C);
        chk("R9 later selector ignored", od_active, 0);
        chk("R9 later bits still decoded", rxbyte, 8'h3C);
    endtask

    task automatic t_reset_end_low;
        int r0;
        r0 = nrst;
        hold(1'b0, 500);
        hold(1'b1, 20);
        hold(1'b0, 100);
        hold(1'b1, 350);
        hold(1'b0, 100);
        hold(1'b1, 560);
        chk("R7 low at reset end gives one later strobe", nrst - r0, 1);
        chk("R7 second sequence presence", last_pres, 0);
    endtask

    task automatic t_saturate;
        int r0, b0;
        r0 = nrst; b0 = nbit;
        hold(1'b0, 4196);
        hold(1'b1, 520);
        chk("R10 very long low is a reset", nrst - r0, 1);
        chk("R10 very long low gives no bit", nbit - b0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_std_traffic();
        t_sync_latency();
        t_long_lows();
        t_fast_entry(8'h3C);
        t_fast_entry(8'h69);
        t_first_byte_only();
        t_reset_end_low();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule